// File: doc/BRIEF.md
# Load/Store Effective Address Unit for a Two-Read-Port Register File

This block sits in a simple pipeline between the decoded instruction and the data memory. For each load or store it is handed the operation type, an addressing mode, up to three register specifiers and a 16-bit immediate. It drives the read and write addresses of a register file that has exactly two read ports and one write port. It then produces the effective address, the store data and a register write-back request. It never asks the register file for more than two reads or one write in a single cycle.

The set of legal modes differs between loads and stores, because each mode is sized to the free register ports. A load reads no data register, so it can spend both read ports on base and index, and register+register costs it nothing. A store leaves the write port idle, so it can write an auto-incremented base back at no cost. The two remaining combinations each need one extra cycle: a register+register store and an auto-indexed load. Each is enabled by its own parameter. When a combination is disabled, or the mode code is reserved, the instruction is flagged illegal and has no other effect.

The effective address is the base register plus either the sign-extended immediate or the index register, in a 32-bit adder that wraps around. Results are registered and appear one cycle after issue. If the instruction needs an extra cycle, `busy` is high during that cycle and any issue offered then is dropped.

Top module: `lsa_addr_unit`

## Requirements
- R1: In the cycle after a cycle with `rst_n` low, `busy`, `res_valid`, `res_illegal` and `wb_en` are all 0.
- R2: Mode code 2'b00 (base+offset) and 2'b10 (auto-index) form the address as base register value plus the 16-bit immediate sign-extended to 32 bits, modulo 2^32. The address appears on `res_addr` with `res_valid` high in the cycle after issue. A load in either mode requests read port A only, addressed by the base specifier.
- R3: Mode code 2'b01 (register+register) on a load requests both read ports in the issue cycle (A = base, B = index). It returns base value + index value, modulo 2^32, in the cycle after issue, with `busy` staying low.
- R4: A store in mode 2'b00 or 2'b10 reads the base on port A and the data register on port B in the issue cycle. It returns `res_store` = 1 and `res_sdata` = data register value in the cycle after issue.
- R5: A store in mode 2'b10 raises `wb_en` in the cycle after issue, with `wb_sel` = 0 (update value), `wb_addr` = base specifier and `wb_data` = the effective address. A store in mode 2'b00 leaves `wb_en` low.
- R6: Every legal load raises `wb_en` in its result cycle, with `wb_sel` = 1 (loaded memory data) and `wb_addr` = the data/destination specifier.
- R7: With `ALLOW_LD_AUTOIDX` = 1, a load in mode 2'b10 holds `busy` high for exactly the cycle after issue. In that cycle it requests no read. In the cycle after that it raises `wb_en` with `wb_sel` = 0, `wb_addr` = base specifier and `wb_data` = the effective address, and `res_valid` stays low.
- R8: With `ALLOW_ST_REGREG` = 1, a store in mode 2'b01 reads base (A) and index (B) in the issue cycle. In the following cycle `busy` is high and only port A is read, addressed by the data specifier. In the cycle after that it returns address = base + index and store data = that register's value, with `wb_en` low.
- R9: Mode 2'b11 is always illegal. A load in mode 2'b10 is illegal when `ALLOW_LD_AUTOIDX` = 0, and a store in mode 2'b01 is illegal when `ALLOW_ST_REGREG` = 0. An illegal issue requests no read. In the next cycle it pulses `res_illegal` with `res_valid`, `wb_en` and `busy` all low.
- R10: An issue offered while `busy` is high is ignored: it drives no read port and produces no result or write-back afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | An instruction is offered this cycle |
| issue_store | input | 1 | 1 = store, 0 = load |
| issue_mode | input | 2 | 00 base+offset, 01 register+register, 10 auto-index, 11 reserved |
| issue_data_reg | input | RIDX | Load destination or store data source |
| issue_base_reg | input | RIDX | Base register specifier |
| issue_index_reg | input | RIDX | Index register specifier |
| issue_imm | input | 16 | Offset constant |
| rf_raddr_a | output | RIDX | Read port A address |
| rf_ren_a | output | 1 | Read port A request |
| rf_rdata_a | input | XLEN | Read port A data (same cycle) |
| rf_raddr_b | output | RIDX | Read port B address |
| rf_ren_b | output | 1 | Read port B request |
| rf_rdata_b | input | XLEN | Read port B data (same cycle) |
| busy | output | 1 | Extra cycle in progress; issue ignored |
| res_valid | output | 1 | Effective address valid |
| res_store | output | 1 | Result belongs to a store |
| res_addr | output | XLEN | Effective address |
| res_sdata | output | XLEN | Store data |
| res_illegal | output | 1 | Illegal instruction pulse |
| wb_en | output | 1 | Write port request |
| wb_sel | output | 1 | 0 = write `wb_data`, 1 = write loaded memory data |
| wb_addr | output | RIDX | Write port register specifier |
| wb_data | output | XLEN | Base update value |

## Verification
The assertions assume that the register file returns read data in the same cycle as the address. They also assume that `issue_mode` and `issue_store` are known whenever `issue_valid` is high. The bench keeps to this with a static register-file model indexed directly by the read addresses, and by always driving defined fields. Random operations never issue during a busy cycle, so the port and result checks stay aligned to one instruction at a time. One directed sequence offers an instruction during the busy cycle on purpose to exercise the drop rule. A second instance with both extra-cycle options disabled receives the same stimulus, which lets the illegal cases be observed.

// File: rtl/lsa_pkg.sv
// Shared types for the load/store address unit.
// Assumes: the two-bit mode code is decoded only here and in the decode module.
package lsa_pkg;
    typedef enum logic [1:0] {
        AM_BASE_OFF = 2'b00,
        AM_REG_REG  = 2'b01,
        AM_AUTO_IDX = 2'b10,
        AM_RSVD     = 2'b11
    } amode_e;

    typedef enum logic [1:0] {
        PD_NONE    = 2'b00,
        PD_ST_RR   = 2'b01,
        PD_LD_BASE = 2'b10
    } pend_e;

    localparam logic WB_BASE = 1'b0;
    localparam logic WB_LOAD = 1'b1;
endpackage

// File: rtl/lsa_decode.sv
// Classifies an offered instruction: legality, operand source for the adder,
// and whether an extra cycle or a base update is needed.
// Assumes: inputs are only meaningful while an issue is offered.
module lsa_decode
    import lsa_pkg::*;
#(
    parameter bit ALLOW_ST_REGREG  = 1'b1,
    parameter bit ALLOW_LD_AUTOIDX = 1'b1
) (
    input  logic       is_store,
    input  logic [1:0] mode,
    output logic       legal,
    output logic       use_idx,
    output logic       two_cyc_st,
    output logic       ld_extra,
    output logic       st_wb
);
    amode_e m;

    // Decode the mode code against the operation type and options.
    always_comb begin
        m          = amode_e'(mode);
        legal      = 1'b1;
        use_idx    = (m == AM_REG_REG);
        two_cyc_st = 1'b0;
        ld_extra   = 1'b0;
        st_wb      = 1'b0;
        case (m)
            AM_REG_REG: begin
                if (is_store) begin
                    legal      = ALLOW_ST_REGREG;
                    two_cyc_st = ALLOW_ST_REGREG;
                end
            end
            AM_AUTO_IDX: begin
                if (is_store) begin
                    st_wb = 1'b1;
                end else begin
                    legal    = ALLOW_LD_AUTOIDX;
                    ld_extra = ALLOW_LD_AUTOIDX;
                end
            end
            AM_RSVD:  legal = 1'b0;
            default:  legal = 1'b1;
        endcase
    end
endmodule

// File: rtl/lsa_adder.sv
// Effective-address adder: base plus either the index value or the
// sign-extended offset, wrapping at XLEN bits.
// Assumes: IMMW < XLEN.
module lsa_adder #(
    parameter int XLEN = 32,
    parameter int IMMW = 16
) (
    input  logic [XLEN-1:0] base_val,
    input  logic [XLEN-1:0] idx_val,
    input  logic [IMMW-1:0] imm,
    input  logic            use_idx,
    output logic [XLEN-1:0] sum
);
    localparam int EXTW = XLEN - IMMW;

    logic [XLEN-1:0] offs;

    // Select the second operand and add with natural wraparound.
    always_comb begin
        offs = use_idx ? idx_val : {{EXTW{imm[IMMW-1]}}, imm};
        sum  = base_val + offs;
    end
endmodule

// File: rtl/lsa_ctrl.sv
// Sequencer and result registers. Holds the pending extra-cycle work
// (store data read, or deferred base update) and registers all outputs.
// Assumes: issue_fire is never high while busy is high.
module lsa_ctrl
    import lsa_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int RIDX = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_fire,
    input  logic            is_store,
    input  logic            legal,
    input  logic            two_cyc_st,
    input  logic            ld_extra,
    input  logic            st_wb,
    input  logic [RIDX-1:0] data_reg,
    input  logic [RIDX-1:0] base_reg,
    input  logic [XLEN-1:0] sum,
    input  logic [XLEN-1:0] rdata_a,
    input  logic [XLEN-1:0] rdata_b,
    output logic            busy,
    output logic            pend_st_rr,
    output logic [RIDX-1:0] pend_reg,
    output logic            res_valid,
    output logic            res_store,
    output logic [XLEN-1:0] res_addr,
    output logic [XLEN-1:0] res_sdata,
    output logic            res_illegal,
    output logic            wb_en,
    output logic            wb_sel,
    output logic [RIDX-1:0] wb_addr,
    output logic [XLEN-1:0] wb_data
);
    pend_e           pend_q;
    logic [XLEN-1:0] pend_sum_q;
    logic [RIDX-1:0] pend_reg_q;

    assign busy       = (pend_q != PD_NONE);
    assign pend_st_rr = (pend_q == PD_ST_RR);
    assign pend_reg   = pend_reg_q;

    // Advance pending work and register the result and write-port request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= PD_NONE;
            pend_sum_q  <= '0;
            pend_reg_q  <= '0;
            res_valid   <= 1'b0;
            res_store   <= 1'b0;
            res_addr    <= '0;
            res_sdata   <= '0;
            res_illegal <= 1'b0;
            wb_en       <= 1'b0;
            wb_sel      <= WB_BASE;
            wb_addr     <= '0;
            wb_data     <= '0;
        end else begin
            res_valid   <= 1'b0;
            res_illegal <= 1'b0;
            wb_en       <= 1'b0;
            case (pend_q)
                PD_ST_RR: begin
                    res_valid <= 1'b1;
                    res_store <= 1'b1;
                    res_addr  <= pend_sum_q;
                    res_sdata <= rdata_a;
                    pend_q    <= PD_NONE;
                end
                PD_LD_BASE: begin
                    wb_en   <= 1'b1;
                    wb_sel  <= WB_BASE;
                    wb_addr <= pend_reg_q;
                    wb_data <= pend_sum_q;
                    pend_q  <= PD_NONE;
                end
                default: begin
                    if (issue_fire) begin
                        if (!legal) begin
                            res_illegal <= 1'b1;
                        end else if (two_cyc_st) begin
                            pend_q     <= PD_ST_RR;
                            pend_sum_q <= sum;
                            pend_reg_q <= data_reg;
                        end else begin
                            res_valid <= 1'b1;
                            res_store <= is_store;
                            res_addr  <= sum;
                            res_sdata <= is_store ? rdata_b : '0;
                            if (!is_store) begin
                                wb_en   <= 1'b1;
                                wb_sel  <= WB_LOAD;
                                wb_addr <= data_reg;
                                wb_data <= '0;
                            end else if (st_wb) begin
                                wb_en   <= 1'b1;
                                wb_sel  <= WB_BASE;
                                wb_addr <= base_reg;
                                wb_data <= sum;
                            end
                            if (ld_extra) begin
                                pend_q     <= PD_LD_BASE;
                                pend_sum_q <= sum;
                                pend_reg_q <= base_reg;
                            end
                        end
                    end
                end
            endcase
        end
    end

    // R1: outputs quiet right after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!busy && !res_valid && !res_illegal && !wb_en));

    // R7 / R8: an extra cycle never lasts more than one cycle
    a_r7_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R9: illegal pulse carries no result and no write
    a_r9_illegal_silent: assert property (@(posedge clk) disable iff (!rst_n)
        res_illegal |-> (!res_valid && !wb_en));

    // R6: a load result always comes with a loaded-data write request
    a_r6_load_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_store) |-> (wb_en && wb_sel == WB_LOAD));

    // R8: a two-cycle store produces its result right after the busy cycle
    a_r8_store_follows: assert property (@(posedge clk) disable iff (!rst_n)
        pend_st_rr |=> (res_valid && res_store && !wb_en));
endmodule

// File: rtl/lsa_addr_unit.sv
// Top of the load/store address unit. Steers the two register-file read
// ports, feeds the adder and hands results to the sequencer.
// Assumes: register-file read data is returned in the same cycle.
module lsa_addr_unit
    import lsa_pkg::*;
#(
    parameter int XLEN             = 32,
    parameter int RIDX             = 5,
    parameter int IMMW             = 16,
    parameter bit ALLOW_ST_REGREG  = 1'b1,
    parameter bit ALLOW_LD_AUTOIDX = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid,
    input  logic            issue_store,
    input  logic [1:0]      issue_mode,
    input  logic [RIDX-1:0] issue_data_reg,
    input  logic [RIDX-1:0] issue_base_reg,
    input  logic [RIDX-1:0] issue_index_reg,
    input  logic [IMMW-1:0] issue_imm,
    output logic [RIDX-1:0] rf_raddr_a,
    output logic            rf_ren_a,
    input  logic [XLEN-1:0] rf_rdata_a,
    output logic [RIDX-1:0] rf_raddr_b,
    output logic            rf_ren_b,
    input  logic [XLEN-1:0] rf_rdata_b,
    output logic            busy,
    output logic            res_valid,
    output logic            res_store,
    output logic [XLEN-1:0] res_addr,
    output logic [XLEN-1:0] res_sdata,
    output logic            res_illegal,
    output logic            wb_en,
    output logic            wb_sel,
    output logic [RIDX-1:0] wb_addr,
    output logic [XLEN-1:0] wb_data
);
    logic            legal, use_idx, two_cyc_st, ld_extra, st_wb;
    logic            pend_st_rr, issue_fire;
    logic [RIDX-1:0] pend_reg;
    logic [XLEN-1:0] sum;

    lsa_decode #(
        .ALLOW_ST_REGREG (ALLOW_ST_REGREG),
        .ALLOW_LD_AUTOIDX(ALLOW_LD_AUTOIDX)
    ) u_decode (
        .is_store  (issue_store),
        .mode      (issue_mode),
        .legal     (legal),
        .use_idx   (use_idx),
        .two_cyc_st(two_cyc_st),
        .ld_extra  (ld_extra),
        .st_wb     (st_wb)
    );

    lsa_adder #(.XLEN(XLEN), .IMMW(IMMW)) u_adder (
        .base_val(rf_rdata_a),
        .idx_val (rf_rdata_b),
        .imm     (issue_imm),
        .use_idx (use_idx),
        .sum     (sum)
    );

    assign issue_fire = issue_valid && !busy;

    // Steer the read ports: pending store-data read first, else the issue.
    always_comb begin
        rf_raddr_a = issue_base_reg;
        rf_raddr_b = use_idx ? issue_index_reg : issue_data_reg;
        rf_ren_a   = 1'b0;
        rf_ren_b   = 1'b0;
        if (pend_st_rr) begin
            rf_raddr_a = pend_reg;
            rf_ren_a   = 1'b1;
        end else if (issue_fire && legal) begin
            rf_ren_a = 1'b1;
            rf_ren_b = issue_store || use_idx;
        end
    end

    lsa_ctrl #(.XLEN(XLEN), .RIDX(RIDX)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_fire (issue_fire),
        .is_store   (issue_store),
        .legal      (legal),
        .two_cyc_st (two_cyc_st),
        .ld_extra   (ld_extra),
        .st_wb      (st_wb),
        .data_reg   (issue_data_reg),
        .base_reg   (issue_base_reg),
        .sum        (sum),
        .rdata_a    (rf_rdata_a),
        .rdata_b    (rf_rdata_b),
        .busy       (busy),
        .pend_st_rr (pend_st_rr),
        .pend_reg   (pend_reg),
        .res_valid  (res_valid),
        .res_store  (res_store),
        .res_addr   (res_addr),
        .res_sdata  (res_sdata),
        .res_illegal(res_illegal),
        .wb_en      (wb_en),
        .wb_sel     (wb_sel),
        .wb_addr    (wb_addr),
        .wb_data    (wb_data)
    );

    // R4: a legal store that fires always occupies both read ports
    a_r4_store_both_ports: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_fire && issue_store && legal && !pend_st_rr) |-> (rf_ren_a && rf_ren_b));

    // R8: the extra store cycle uses port A only
    a_r8_extra_read_a: assert property (@(posedge clk) disable iff (!rst_n)
        pend_st_rr |-> (rf_ren_a && !rf_ren_b));

    // R7 / R10: the deferred base-update cycle reads nothing
    a_r7_update_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pend_st_rr) |-> (!rf_ren_a && !rf_ren_b));

    // R9: an illegal issue requests no read
    a_r9_illegal_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_fire && !legal) |-> (!rf_ren_a && !rf_ren_b));
endmodule

// File: tb/test_lsa_addr_unit.sv
module test_lsa_addr_unit;
    localparam int XLEN = 32;
    localparam int RIDX = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic            issue_valid = 1'b0, issue_store = 1'b0;
    logic [1:0]      issue_mode = 2'b00;
    logic [RIDX-1:0] d_reg = '0, b_reg = '0, x_reg = '0;
    logic [15:0]     imm = '0;

    logic [XLEN-1:0] rf [32];

    logic [RIDX-1:0] raddr_a, raddr_b, wb_addr;
    logic            ren_a, ren_b, busy, res_valid, res_store, res_illegal, wb_en, wb_sel;
    logic [XLEN-1:0] rdata_a, rdata_b, res_addr, res_sdata, wb_data;

    logic [RIDX-1:0] s_raddr_a, s_raddr_b, s_wb_addr;
    logic            s_ren_a, s_ren_b, s_busy, s_res_valid, s_res_store, s_res_illegal, s_wb_en, s_wb_sel;
    logic [XLEN-1:0] s_rdata_a, s_rdata_b, s_res_addr, s_res_sdata, s_wb_data;

    assign rdata_a   = rf[raddr_a];
    assign rdata_b   = rf[raddr_b];
    assign s_rdata_a = rf[s_raddr_a];
    assign s_rdata_b = rf[s_raddr_b];

    lsa_addr_unit i_lsa_addr_unit (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_store(issue_store),
        .issue_mode(issue_mode), .issue_data_reg(d_reg), .issue_base_reg(b_reg),
        .issue_index_reg(x_reg), .issue_imm(imm),
        .rf_raddr_a(raddr_a), .rf_ren_a(ren_a), .rf_rdata_a(rdata_a),
        .rf_raddr_b(raddr_b), .rf_ren_b(ren_b), .rf_rdata_b(rdata_b),
        .busy(busy), .res_valid(res_valid), .res_store(res_store), .res_addr(res_addr),
        .res_sdata(res_sdata), .res_illegal(res_illegal), .wb_en(wb_en), .wb_sel(wb_sel),
        .wb_addr(wb_addr), .wb_data(wb_data)
    );

    lsa_addr_unit #(.ALLOW_ST_REGREG(1'b0), .ALLOW_LD_AUTOIDX(1'b0)) i_lsa_addr_unit_strict (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_store(issue_store),
        .issue_mode(issue_mode), .issue_data_reg(d_reg), .issue_base_reg(b_reg),
        .issue_index_reg(x_reg), .issue_imm(imm),
        .rf_raddr_a(s_raddr_a), .rf_ren_a(s_ren_a), .rf_rdata_a(s_rdata_a),
        .rf_raddr_b(s_raddr_b), .rf_ren_b(s_ren_b), .rf_rdata_b(s_rdata_b),
        .busy(s_busy), .res_valid(s_res_valid), .res_store(s_res_store), .res_addr(s_res_addr),
        .res_sdata(s_res_sdata), .res_illegal(s_res_illegal), .wb_en(s_wb_en), .wb_sel(s_wb_sel),
        .wb_addr(s_wb_addr), .wb_data(s_wb_data)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [XLEN-1:0] exp_ea(input logic [1:0] m, input logic [RIDX-1:0] b,
                                               input logic [RIDX-1:0] x, input logic [15:0] i);
        if (m == 2'b01) return rf[b] + rf[x];
        return rf[b] + {{16{i[15]}}, i};
    endfunction

    // Issue one instruction on the default unit and check it end to end.
    task automatic run_op(input logic st, input logic [1:0] m, input logic [RIDX-1:0] d,
                          input logic [RIDX-1:0] b, input logic [RIDX-1:0] x, input logic [15:0] i);
        logic [XLEN-1:0] ea;
        bit illegal, st_rr, ld_ai, strict_ill;
        ea         = exp_ea(m, b, x, i);
        illegal    = (m == 2'b11);
        st_rr      = st && (m == 2'b01);
        ld_ai      = !st && (m == 2'b10);
        strict_ill = illegal || st_rr || ld_ai;
        issue_valid = 1'b1; issue_store = st; issue_mode = m;
        d_reg = d; b_reg = b; x_reg = x; imm = i;
        #1;
        if (illegal) begin
            chk("R9 illegal ren_a", ren_a, 0);
            chk("R9 illegal ren_b", ren_b, 0);
        end else begin
            chk("R2 issue ren_a", ren_a, 1);
            chk("R2 issue raddr_a=base", raddr_a, b);
            if (st && !st_rr) begin
                chk("R4 store ren_b", ren_b, 1);
                chk("R4 store raddr_b=data", raddr_b, d);
            end else if (m == 2'b01) begin
                chk("R3/R8 ren_b", ren_b, 1);
                chk("R3/R8 raddr_b=index", raddr_b, x);
            end else begin
                chk("R2 load ren_b", ren_b, 0);
            end
        end
        if (strict_ill) begin
            chk("R9 strict ren_a", s_ren_a, 0);
            chk("R9 strict ren_b", s_ren_b, 0);
        end
        @(negedge clk);
        issue_valid = 1'b0;
        chk("R9 strict illegal flag", s_res_illegal, strict_ill);
        if (illegal) begin
            chk("R9 illegal pulse", res_illegal, 1);
            chk("R9 illegal no result", res_valid, 0);
            chk("R9 illegal no wb", wb_en, 0);
            chk("R9 illegal no busy", busy, 0);
        end else if (st_rr) begin
            chk("R8 busy", busy, 1);
            chk("R8 no result yet", res_valid, 0);
            chk("R8 extra ren_a", ren_a, 1);
            chk("R8 extra ren_b", ren_b, 0);
            chk("R8 extra raddr_a=data", raddr_a, d);
            @(negedge clk);
            chk("R8 result valid", res_valid, 1);
            chk("R8 res_store", res_store, 1);
            chk("R8 address", res_addr, ea);
            chk("R8 store data", res_sdata, rf[d]);
            chk("R8 no wb", wb_en, 0);
            chk("R8 busy cleared", busy, 0);
        end else begin
            chk("R2 result valid", res_valid, 1);
            chk("R2/R3 address", res_addr, ea);
            chk("R2 res_store", res_store, st);
            chk("R3 illegal low", res_illegal, 0);
            if (st) begin
                chk("R4 store data", res_sdata, rf[d]);
                chk("R4 busy low", busy, 0);
                chk("R5 wb_en", wb_en, (m == 2'b10));
                if (m == 2'b10) begin
                    chk("R5 wb_sel", wb_sel, 0);
                    chk("R5 wb_addr", wb_addr, b);
                    chk("R5 wb_data", wb_data, ea);
                end
            end else begin
                chk("R6 wb_en", wb_en, 1);
                chk("R6 wb_sel", wb_sel, 1);
                chk("R6 wb_addr", wb_addr, d);
                chk("R7 busy", busy, ld_ai);
                if (ld_ai) begin
                    chk("R7 no read ren_a", ren_a, 0);
                    chk("R7 no read ren_b", ren_b, 0);
                    @(negedge clk);
                    chk("R7 base wb_en", wb_en, 1);
                    chk("R7 base wb_sel", wb_sel, 0);
                    chk("R7 base wb_addr", wb_addr, b);
                    chk("R7 base wb_data", wb_data, ea);
                    chk("R7 no result", res_valid, 0);
                    chk("R7 busy cleared", busy, 0);
                end
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [XLEN-1:0] ea0;
        void'($urandom(32'h1357_2468));
        for (int k = 0; k < 32; k++) rf[k] = $urandom;
        repeat (3) @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 res_valid", res_valid, 0);
        chk("R1 res_illegal", res_illegal, 0);
        chk("R1 wb_en", wb_en, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners: negative offset, wraparound, all modes and types.
        rf[1] = 32'hFFFF_FFF0; rf[2] = 32'h0000_0040; rf[3] = 32'h1234_5678;
        run_op(1'b0, 2'b00, 5'd4, 5'd2, 5'd0, 16'h8000);
        run_op(1'b0, 2'b00, 5'd4, 5'd1, 5'd0, 16'h0020);
        run_op(1'b0, 2'b01, 5'd4, 5'd1, 5'd2, 16'h0000);
        run_op(1'b0, 2'b10, 5'd4, 5'd1, 5'd0, 16'hFFFF);
        run_op(1'b1, 2'b00, 5'd3, 5'd2, 5'd0, 16'h7FFF);
        run_op(1'b1, 2'b01, 5'd3, 5'd1, 5'd2, 16'h0000);
        run_op(1'b1, 2'b10, 5'd3, 5'd1, 5'd0, 16'h0030);
        run_op(1'b0, 2'b11, 5'd4, 5'd1, 5'd2, 16'h0001);
        run_op(1'b1, 2'b11, 5'd3, 5'd1, 5'd2, 16'h0001);

        // R10: issue offered during the busy cycle of a two-cycle store is dropped.
        issue_valid = 1'b1; issue_store = 1'b1; issue_mode = 2'b01;
        d_reg = 5'd3; b_reg = 5'd1; x_reg = 5'd2; imm = '0;
        ea0 = rf[1] + rf[2];
        @(negedge clk);
        issue_store = 1'b0; issue_mode = 2'b00; d_reg = 5'd9; b_reg = 5'd7;
        #1;
        chk("R10 busy", busy, 1);
        chk("R10 port A stays on data reg", raddr_a, 5'd3);
        chk("R10 no port B", ren_b, 0);
        @(negedge clk);
        issue_valid = 1'b0;
        chk("R10 store result kept", res_addr, ea0);
        chk("R10 result is store", res_store, 1);
        @(negedge clk);
        chk("R10 dropped issue no result", res_valid, 0);
        chk("R10 dropped issue no wb", wb_en, 0);

        // R10: issue offered during the base-update cycle of an auto-indexed load.
        issue_valid = 1'b1; issue_store = 1'b0; issue_mode = 2'b10;
        d_reg = 5'd5; b_reg = 5'd2; imm = 16'h0008;
        @(negedge clk);
        issue_mode = 2'b01; d_reg = 5'd6; b_reg = 5'd3; x_reg = 5'd1;
        #1;
        chk("R10 update cycle no read", ren_a, 0);
        @(negedge clk);
        issue_valid = 1'b0;
        chk("R10 base wb addr", wb_addr, 5'd2);
        @(negedge clk);
        chk("R10 dropped load no result", res_valid, 0);
        chk("R10 dropped load no wb", wb_en, 0);

        // Constrained random mix.
        for (int n = 0; n < 400; n++) begin
            if (n % 50 == 0) for (int k = 0; k < 32; k++) rf[k] = $urandom;
            run_op(1'($urandom), 2'($urandom), 5'($urandom), 5'($urandom), 5'($urandom), 16'($urandom));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule